// File: doc/BRIEF.md
# System Control Port with Refresh Toggle

This block is a one-byte system control register that sits beside a three-channel interval timer and drives a tone output. A write sets two control bits. Bit 0 is the gate of timer channel 2, and bit 1 enables speaker data. The gates of timer channels 0 and 1 are held high. A read returns those two control bits together with two live status bits:

- the current output of timer channel 2;
- a refresh flag that flips at a fixed period. A prescaler counts down the system clock to produce this flag.

The speaker output is channel 2's output masked by the speaker data enable.

The refresh flag comes from a two-state machine. In state `RF_LOW` the flag reads 0, and in state `RF_HIGH` it reads 1. The machine takes transition `FLIP_UP` (`RF_LOW` to `RF_HIGH`) and transition `FLIP_DOWN` (`RF_HIGH` to `RF_LOW`) on the prescaler's terminal count. In every other cycle it stays in its current state.

The prescaler period is the nominal 15.085 us interval rounded to the nearest whole number of system clock cycles, computed from the parameter `CLK_HZ`. At the default 200 MHz this is 3017 cycles.

Top module: `sysctl_port`

## Requirements
- R1: After reset the gate of channel 2 and the speaker enable are 0, the refresh flag is 0, and `rd_data` reads 0x00 while `tmr2_out` is 0.
- R2: `gate_ch0` and `gate_ch1` are 1 at all times.
- R3: A write with `wr_en` high copies `wr_data` bit 0 into the channel 2 gate. The new value appears on `gate_ch2` and on `rd_data` bit 0 one clock edge later.
- R4: A write copies `wr_data` bit 1 into the speaker enable, which is shown on `rd_data` bit 1 one edge later. Write bits 7 to 2 have no effect.
- R5: While `wr_en` is low, the gate and the speaker enable keep their values whatever `wr_data` holds.
- R6: `rd_data` bit 5 equals `tmr2_out` in the same cycle, with no register in the path.
- R7: `rd_data` bit 4 flips once every P clock cycles, where P = round(CLK_HZ * REFRESH_NS / 1e9). P is 3017 with the defaults.
- R8: `rd_data` bits 2, 3, 6 and 7 always read 0.
- R9: `spk_out` equals `tmr2_out` AND the speaker enable, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte (bit 0 gate, bit 1 speaker enable) |
| tmr2_out | input | 1 | Output of timer channel 2 |
| rd_data | output | 8 | Status byte (bit 0 gate, 1 enable, 4 refresh, 5 timer 2 output) |
| gate_ch0 | output | 1 | Gate of timer channel 0, fixed high |
| gate_ch1 | output | 1 | Gate of timer channel 1, fixed high |
| gate_ch2 | output | 1 | Gate of timer channel 2 |
| spk_out | output | 1 | Speaker drive: timer 2 output AND enable |

## Verification
A written control bit is due on `gate_ch2` and `rd_data` one edge after the strobe edge. Bit 5 of `rd_data` and `spk_out` follow `tmr2_out` in the same cycle, and the refresh flag changes exactly 3017 cycles after its previous change. Each stimulus step applies its inputs just after a rising edge and lets one more rising edge pass. It then queues the expected byte, and a monitor compares it at the following falling edge, so both registered and combinational results are settled. A separate watcher logs the cycle of every refresh flip and checks the spacing between flips.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
    typedef enum logic {
        RF_LOW  = 1'b0,
        RF_HIGH = 1'b1
    } refresh_state_e;

    typedef struct packed {
        logic spk_en;
        logic gate2;
    } ctl_t;

    localparam int RD_GATE2_BIT   = 0;
    localparam int RD_SPKEN_BIT   = 1;
    localparam int RD_REFRESH_BIT = 4;
    localparam int RD_T2OUT_BIT   = 5;
endpackage

// File: rtl/sysctl_refresh.sv
`timescale 1ns/1ps
module sysctl_refresh
    import sysctl_pkg::*;
#(
    parameter int PERIOD = 3017
) (
    input  logic clk,
    input  logic rst_n,
    output logic refresh_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    refresh_state_e   state_q, state_d;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RF_LOW;
        else
            state_q <= state_d;
    end

    // Next state: FLIP_UP / FLIP_DOWN on terminal count
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_LOW:  if (tick) state_d = RF_HIGH;
            RF_HIGH: if (tick) state_d = RF_LOW;
        endcase
    end

    // Output process
    always_comb begin
        refresh_o = 1'b0;
        unique case (state_q)
            RF_LOW:  refresh_o = 1'b0;
            RF_HIGH: refresh_o = 1'b1;
        endcase
    end

    a_r7_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (refresh_o != $past(refresh_o)));
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(refresh_o));
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/sysctl_ctlreg.sv
`timescale 1ns/1ps
module sysctl_ctlreg
    import sysctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output ctl_t          ctl_o
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en) begin
            ctl_q.gate2  <= wr_data[RD_GATE2_BIT];
            ctl_q.spk_en <= wr_data[RD_SPKEN_BIT];
        end
    end

    assign ctl_o = ctl_q;

    a_r3_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_o.gate2 == $past(wr_data[RD_GATE2_BIT]));
    a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_o.spk_en == $past(wr_data[RD_SPKEN_BIT]));
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_o));
endmodule

// File: rtl/sysctl_port.sv
`timescale 1ns/1ps
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int REFRESH_NS = 15085
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tmr2_out,
    output logic [7:0] rd_data,
    output logic       gate_ch0,
    output logic       gate_ch1,
    output logic       gate_ch2,
    output logic       spk_out
);
    localparam longint unsigned PROD = 64'(CLK_HZ) * 64'(REFRESH_NS);
    localparam int PERIOD_RAW = int'((PROD + 64'd500_000_000) / 64'd1_000_000_000);
    localparam int PERIOD     = (PERIOD_RAW < 1) ? 1 : PERIOD_RAW;

    ctl_t ctl;
    logic refresh;

    sysctl_ctlreg #(.DW(8)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_o   (ctl)
    );

    sysctl_refresh #(.PERIOD(PERIOD)) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh_o (refresh)
    );

    always_comb begin
        rd_data                 = '0;
        rd_data[RD_GATE2_BIT]   = ctl.gate2;
        rd_data[RD_SPKEN_BIT]   = ctl.spk_en;
        rd_data[RD_REFRESH_BIT] = refresh;
        rd_data[RD_T2OUT_BIT]   = tmr2_out;
    end

    assign gate_ch0 = 1'b1;
    assign gate_ch1 = 1'b1;
    assign gate_ch2 = ctl.gate2;
    assign spk_out  = tmr2_out & ctl.spk_en;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (gate_ch2 == 1'b0 && rd_data[RD_SPKEN_BIT] == 1'b0 && rd_data[RD_REFRESH_BIT] == 1'b0));
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 8'hCC) == 8'h00);
endmodule

// File: tb/sim_sysctl_port.sv
`timescale 1ns/1ps
module sim_sysctl_port;
    typedef struct {
        string      tag;
        logic [7:0] mask;
        logic [7:0] exp_rd;
        logic       exp_spk;
        logic       exp_g2;
    } item_t;

    localparam int EXP_PERIOD = 3017; // 200e6 * 15.085e-6

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tmr2_out = 1'b0;
    logic [7:0] rd_data;
    logic       gate_ch0, gate_ch1, gate_ch2, spk_out;

    int checks = 0;
    int errors = 0;
    item_t q[$];
    logic m_g2 = 1'b0;
    logic m_en = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tmr2_out(tmr2_out), .rd_data(rd_data), .gate_ch0(gate_ch0),
        .gate_ch1(gate_ch1), .gate_ch2(gate_ch2), .spk_out(spk_out)
    );

    task automatic push_exp(input string tag, input logic [7:0] mask);
        item_t it;
        it.tag     = tag;
        it.mask    = mask;
        it.exp_rd  = {2'b00, tmr2_out, 3'b000, m_en, m_g2};
        it.exp_spk = tmr2_out & m_en;
        it.exp_g2  = m_g2;
        q.push_back(it);
    endtask

    task automatic step(input string tag, input logic we, input logic [7:0] d, input logic t2);
        @(posedge clk);
        #1;
        wr_en = we; wr_data = d; tmr2_out = t2;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (we) begin
            m_g2 = d[0];
            m_en = d[1];
        end
        push_exp(tag, 8'hEF);
    endtask

    // Monitor: pops expectations at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ((rd_data & it.mask) !== (it.exp_rd & it.mask)) begin
                errors++;
                $display("FAIL %s rd_data actual %02h expected %02h (mask %02h)", it.tag, rd_data, it.exp_rd, it.mask);
            end
            checks++;
            if (spk_out !== it.exp_spk || gate_ch2 !== it.exp_g2) begin
                errors++;
                $display("FAIL %s spk/gate2 actual %b/%b expected %b/%b", it.tag, spk_out, gate_ch2, it.exp_spk, it.exp_g2);
            end
            checks++; // R2: fixed gates
            if (gate_ch0 !== 1'b1 || gate_ch1 !== 1'b1) begin
                errors++;
                $display("FAIL R2 gate0/gate1 actual %b/%b expected 1/1", gate_ch0, gate_ch1);
            end
        end
    end

    // Refresh watcher for R7
    int cyc = 0;
    int last_flip = -1;
    int flips = 0;
    logic prev_ref = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (rd_data[4] !== prev_ref) begin
                if (last_flip >= 0) begin
                    checks++;
                    if (cyc - last_flip != EXP_PERIOD) begin
                        errors++;
                        $display("FAIL R7 refresh spacing actual %0d expected %0d", cyc - last_flip, EXP_PERIOD);
                    end
                end
                last_flip = cyc;
                flips++;
            end
            prev_ref = rd_data[4];
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        push_exp("R1", 8'hFF);                  // R1: all clear after reset
        step("R3", 1'b1, 8'h01, 1'b0);          // R3: gate set
        step("R6", 1'b0, 8'h00, 1'b1);          // R6: timer out visible, enable off
        step("R4", 1'b1, 8'h03, 1'b1);          // R4/R9: enable on, speaker driven
        step("R9", 1'b0, 8'h00, 1'b0);          // R9: timer low drops speaker
        step("R5", 1'b0, 8'hFC, 1'b1);          // R5: data without strobe ignored
        step("R4", 1'b1, 8'hFC, 1'b1);          // R4: upper bits have no effect
        step("R4", 1'b1, 8'h02, 1'b1);          // R4: enable only
        step("R3", 1'b1, 8'hFD, 1'b0);          // R3: gate only, upper bits ignored
        step("R8", 1'b1, 8'hFF, 1'b1);          // R8: reserved bits stay zero
        step("R9", 1'b1, 8'h01, 1'b1);          // R9: enable off masks speaker
        while (flips < 4) @(posedge clk);
        checks++;
        if (flips < 4) begin
            errors++;
            $display("FAIL R7 flip count actual %0d expected 4", flips);
        end
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule